// File: doc/BRIEF.md
# Write-Only Serial Control Register Loader

This block is a two-wire serial slave that can only be written. It fills a small bank of byte-wide control registers, for example the per-output enable bits of a clock distribution buffer. The serial clock and data pins are brought into a faster system clock domain through two-flop synchronizers. Start and stop conditions and clock edges are found on the synchronized copies. The slave acknowledges by raising an output-enable that pulls the open-drain data line low.

A transfer opens with a start condition and the address byte 0xD2. Two more bytes follow: a command byte and a count byte. The block acknowledges both and discards their contents. Every byte after those two goes to the next register in turn, beginning at register 0. There is no sub-address, so reaching register k means rewriting registers 0 to k-1 in the same transfer. The register values are presented as a parallel output vector. A power-on reset is the only thing that restores the default values. A power-down input forces the exported outputs to zero but leaves the stored contents unchanged.

Top module: `serctl_slave`

## Requirements
- R1: A synchronous active-low power-on reset loads every register with its parameter default (0xFF for each byte by default). While the power-down input is high, the parallel output reads all zeros. The stored contents are not altered, and they reappear when power-down goes low.
- R2: A falling data edge while the clock is high is a start condition and opens a transfer. A rising data edge while the clock is high is a stop condition and closes it. After a stop, bytes sent without a new start are neither acknowledged nor written.
- R3: Bytes are received most significant bit first. The data output-enable stays low while the 8 bits of a byte are on the bus. For an accepted byte it rises after the clock falling edge that ends bit 8. It stays high through the ninth clock and drops after the clock falling edge that ends the ninth clock.
- R4: The first byte after a start is acknowledged only when it equals 0xD2. Any other value, including 0xD3, is not acknowledged, and every byte after it is ignored until the next start condition.
- R5: The two bytes that follow a matched address are acknowledged, and their values change no register.
- R6: The bytes that follow those two are acknowledged and written to registers 0, 1, 2 and onward in that order. Register i sits in output bits [8*i+7:8*i].
- R7: At most 10 data bytes are taken per transfer. Any further data byte is neither acknowledged nor written.
- R8: A start condition in the middle of a transfer drops the partly received byte and restarts address matching. Registers already written in that transfer keep their new values.
- R9: A register keeps its value until it is written again. This holds across completed transfers, aborted transfers and unmatched addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| pwr_dn | input | 1 | Power-down: zeroes the parallel outputs and keeps the register contents |
| scl_in | input | 1 | Serial clock pin, asynchronous |
| sda_in | input | 1 | Serial data pin level, asynchronous |
| sda_oe | output | 1 | Pulls the data line low to acknowledge |
| ctrl_q | output | 80 | Register bank, register i in bits [8*i+7:8*i] |

## Verification
Several behaviours are checked by the assertions on every cycle. The acknowledge enable can only rise on the cycle after a detected clock falling edge. It is never raised while the slave is ignoring the bus. A start always clears the bit and byte position. A stop always returns the slave to idle. A register only changes when it receives a write strobe. Other behaviours can only be shown by the bench's scenarios: which address values are matched, that the command and count bytes are discarded, the order in which registers fill, the cut-off after ten data bytes, what survives a repeated start, and the masking done by power-down.

// File: rtl/serctl_pkg.sv
// Package: shared types for the write-only serial control slave.
// Assumes: nothing beyond standard SystemVerilog.
package serctl_pkg;
    // Receive engine phase
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // waiting for a start condition
        PH_RX   = 2'd1,   // shifting in the bits of a byte
        PH_ACK  = 2'd2,   // driving the acknowledge slot
        PH_SKIP = 2'd3    // byte refused, ignore bus until next start
    } phase_t;

    localparam int unsigned HDR_BYTES = 3;  // address, command, count
endpackage

// File: rtl/serctl_sync.sv
// Module: serctl_sync
// Brings asynchronous pins into the clk domain with a chain of flops per bit.
// Assumes: the bus idles high, so the flops reset to 1.
module serctl_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: one synchronizer stage for all bits
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '1;
                else if (s == 0) chain[s] <= d_async;
                else chain[s] <= chain[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/serctl_cond.sv
// Module: serctl_cond
// Finds clock edges and start/stop conditions on synchronized bus lines.
// Assumes: inputs already synchronized; bus idle level is high.
module serctl_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_p, sda_p;

    // Purpose: hold previous line levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Purpose: decode edges and bus conditions
    always_comb begin
        scl_rise = scl_s & ~scl_p;
        scl_fall = ~scl_s & scl_p;
        start_c  = scl_s & scl_p & sda_p & ~sda_s;
        stop_c   = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/serctl_engine.sv
// Module: serctl_engine
// Byte receiver: matches the address, discards two header bytes, issues
// register writes for the data bytes and drives the acknowledge enable.
// Assumes: one-cycle condition pulses from serctl_cond.
module serctl_engine
    import serctl_pkg::*;
#(
    parameter int unsigned NREG     = 10,
    parameter logic [7:0]  DEV_BYTE = 8'hD2,
    localparam int unsigned IDXW    = $clog2(NREG + HDR_BYTES + 1),
    localparam int unsigned AW      = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_c,
    input  logic          stop_c,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    localparam logic [IDXW-1:0] IDX_MAX = IDXW'(NREG + HDR_BYTES);
    localparam logic [IDXW-1:0] IDX_HDR = IDXW'(HDR_BYTES);

    phase_t          phase;
    logic [3:0]      bit_cnt;
    logic [IDXW-1:0] byte_idx;
    logic [7:0]      shreg;
    logic [IDXW-1:0] data_idx;
    logic            byte_done;
    logic            take;

    // Purpose: classify the completed byte and form the write strobe
    always_comb begin
        data_idx  = byte_idx - IDX_HDR;
        byte_done = (phase == PH_RX) && scl_fall && (bit_cnt == 4'd8)
                    && !start_c && !stop_c;
        if (byte_idx == '0)          take = (shreg == DEV_BYTE);
        else if (byte_idx < IDX_HDR) take = 1'b1;
        else                         take = (data_idx < IDXW'(NREG));
        wr_en   = byte_done && (byte_idx >= IDX_HDR) && take;
        wr_addr = AW'(data_idx);
        wr_data = shreg;
    end

    // Purpose: receive phase, bit/byte counting and acknowledge drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            bit_cnt  <= '0;
            byte_idx <= '0;
            shreg    <= '0;
            sda_oe   <= 1'b0;
        end else if (start_c) begin
            phase    <= PH_RX;
            bit_cnt  <= '0;
            byte_idx <= '0;
            sda_oe   <= 1'b0;
        end else if (stop_c) begin
            phase  <= PH_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (phase)
                PH_RX: begin
                    if (scl_rise && bit_cnt != 4'd8) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        if (take) begin
                            sda_oe <= 1'b1;
                            phase  <= PH_ACK;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        sda_oe  <= 1'b0;
                        phase   <= PH_RX;
                        bit_cnt <= '0;
                        if (byte_idx != IDX_MAX) byte_idx <= byte_idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R3
    ack_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));
    // R4
    skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SKIP) |-> !sda_oe);
    // R8
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> (bit_cnt == 4'd0 && byte_idx == '0 && !sda_oe));
    // R2
    stop_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> (phase == PH_IDLE && !sda_oe));
    // R7
    write_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < AW'(NREG)));
endmodule

// File: rtl/serctl_regs.sv
// Module: serctl_regs
// Control register bank with power-on defaults and power-down output mask.
// Assumes: at most one write per cycle; pwr_dn never touches storage.
module serctl_regs #(
    parameter int unsigned         NREG    = 10,
    parameter logic [NREG*8-1:0]   RST_VAL = {NREG{8'hFF}},
    localparam int unsigned        AW      = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [7:0]        wr_data,
    output logic [NREG*8-1:0] ctrl_q
);
    logic [7:0] regs [NREG];

    // Purpose: power-on defaults and sequential byte writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= RST_VAL[i*8 +: 8];
        end else if (wr_en) begin
            regs[wr_addr] <= wr_data;
        end
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_out
            assign ctrl_q[g*8 +: 8] = pwr_dn ? 8'h00 : regs[g];

            // R9
            reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && wr_addr == AW'(g)) |=> $stable(regs[g]));
        end
    endgenerate
endmodule

// File: rtl/serctl_slave.sv
// Module: serctl_slave (top)
// Write-only two-wire slave loading a bank of control registers.
// Assumes: clk runs at least several times faster than the serial clock;
// the data pad is open-drain and sda_oe pulls it low.
module serctl_slave #(
    parameter int unsigned       NREG     = 10,
    parameter logic [7:0]        DEV_BYTE = 8'hD2,
    parameter logic [NREG*8-1:0] RST_VAL  = {NREG{8'hFF}},
    parameter int unsigned       STAGES   = 2,
    localparam int unsigned      AW       = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [NREG*8-1:0] ctrl_q
);
    logic [1:0]    pins_s;
    logic          scl_rise, scl_fall, start_c, stop_c;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;

    serctl_sync #(.W(2), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({scl_in, sda_in}), .d_sync(pins_s)
    );

    serctl_cond u_cond (
        .clk(clk), .rst_n(rst_n),
        .scl_s(pins_s[1]), .sda_s(pins_s[0]),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_c(start_c), .stop_c(stop_c)
    );

    serctl_engine #(.NREG(NREG), .DEV_BYTE(DEV_BYTE)) u_eng (
        .clk(clk), .rst_n(rst_n), .sda_s(pins_s[0]),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_c(start_c), .stop_c(stop_c),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    serctl_regs #(.NREG(NREG), .RST_VAL(RST_VAL)) u_regs (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl_q(ctrl_q)
    );
endmodule

// File: tb/tb_serctl_slave.sv
module tb_serctl_slave;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 6;     // system cycles per serial half phase
    localparam int NREG       = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_dn = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] ctrl_q;
    wire  sda_line = m_sda & ~sda_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] exp_regs [NREG];
    logic [7:0] pay [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    serctl_slave dut (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn),
        .scl_in(m_scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .ctrl_q(ctrl_q)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [NREG*8-1:0] act,
                         input logic [NREG*8-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NREG*8-1:0] exp_flat();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = exp_regs[i];
        return v;
    endfunction

    // expected acknowledge for byte position pos of a transfer
    function automatic bit exp_ack(input int pos, input logic [7:0] addr);
        if (pos == 0) return addr == 8'hD2;
        if (pos < 3)  return 1'b1;
        return (pos - 3) < NREG;
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; wait_clk(H);
        m_scl = 1'b1; wait_clk(H);
        m_sda = 1'b0; wait_clk(H);
        m_scl = 1'b0; wait_clk(H);
    endtask

    task automatic bus_stop();
        m_scl = 1'b0;
        m_sda = 1'b0; wait_clk(H);
        m_scl = 1'b1; wait_clk(H);
        m_sda = 1'b1; wait_clk(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int k, output bit oe_seen);
        oe_seen = 1'b0;
        m_scl = 1'b0;
        for (int i = 7; i > 7 - k; i--) begin
            m_sda = b[i]; wait_clk(H);
            m_scl = 1'b1; wait_clk(H/2);
            if (sda_oe) oe_seen = 1'b1;
            wait_clk(H - H/2);
            m_scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack, output bit rel_ok,
                             output bit oe_seen);
        send_bits(b, 8, oe_seen);
        m_sda = 1'b1; wait_clk(H);
        m_scl = 1'b1; wait_clk(H/2);
        ack = sda_oe;
        wait_clk(H - H/2);
        m_scl = 1'b0; wait_clk(H);
        rel_ok = !sda_oe;
    endtask

    // full transfer: address, command, count, then n data bytes from pay[]
    task automatic xfer(input logic [7:0] addr, input int n, input bit do_stop);
        bit alive = 1'b1;
        for (int pos = 0; pos < n + 3; pos++) begin
            bit ack, rel, oe_seen, e;
            logic [7:0] b;
            string tag;
            b   = (pos == 0) ? addr : (pos < 3) ? 8'($urandom) : pay[pos-3];
            e   = alive && exp_ack(pos, addr);
            tag = (pos == 0) ? "R4 address ack" : (pos < 3) ? "R5 header ack" :
                  (pos - 3 < NREG) ? "R6 data ack" : "R7 excess data ack";
            if (!alive && pos > 0) tag = "R4 ignored after refusal";
            send_byte(b, ack, rel, oe_seen);
            check(tag, NREG*8'(ack), NREG*8'(e));
            check("R3 no drive during bits", NREG*8'(oe_seen), '0);
            if (e) check("R3 ack release", NREG*8'(rel), NREG*8'(1));
            if (e && pos >= 3) exp_regs[pos-3] = b;
            if (!e) alive = 1'b0;
        end
        if (do_stop) bus_stop();
        wait_clk(4);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ack, rel, oe_seen;
        void'($urandom(32'd1234));
        for (int i = 0; i < NREG; i++) exp_regs[i] = 8'hFF;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        // R1 reset defaults
        check("R1 reset defaults", ctrl_q, exp_flat());

        // R6 full sequential write, R5 header ignored
        for (int i = 0; i < NREG; i++) pay[i] = 8'(8'h10 + i * 8'h11);
        bus_start(); xfer(8'hD2, NREG, 1'b1);
        check("R6 sequential fill / R5 header ignored", ctrl_q, exp_flat());

        // R7 twelve data bytes: last two refused
        for (int i = 0; i < 12; i++) pay[i] = 8'(8'hA0 ^ (i * 8'h07));
        bus_start(); xfer(8'hD2, 12, 1'b1);
        check("R7 limit of ten data bytes", ctrl_q, exp_flat());

        // R4 read form and foreign address
        for (int i = 0; i < 4; i++) pay[i] = 8'h5C;
        bus_start(); xfer(8'hD3, 4, 1'b1);
        check("R4 read address writes nothing", ctrl_q, exp_flat());
        bus_start(); xfer(8'h5A, 4, 1'b1);
        check("R4 foreign address writes nothing", ctrl_q, exp_flat());

        // R2 byte after stop without start
        send_byte(8'hD2, ack, rel, oe_seen);
        check("R2 no ack after stop", NREG*8'(ack), '0);
        send_byte(8'h33, ack, rel, oe_seen);
        check("R2 no write after stop", ctrl_q, exp_flat());
        bus_stop();

        // R8 repeated start mid-byte
        pay[0] = 8'h01; pay[1] = 8'h02;
        bus_start(); xfer(8'hD2, 2, 1'b0);
        send_bits(8'hE7, 3, oe_seen);
        pay[0] = 8'h3C;
        bus_start(); xfer(8'hD2, 1, 1'b1);
        check("R8 repeated start keeps earlier writes", ctrl_q, exp_flat());

        // R9 short write retains upper registers
        pay[0] = 8'h81; pay[1] = 8'h42; pay[2] = 8'h24;
        bus_start(); xfer(8'hD2, 3, 1'b1);
        check("R9 untouched registers retained", ctrl_q, exp_flat());

        // R1 power-down masks outputs, keeps contents
        pwr_dn = 1'b1; wait_clk(3);
        check("R1 power-down zeroes outputs", ctrl_q, '0);
        pwr_dn = 1'b0; wait_clk(3);
        check("R1 contents kept over power-down", ctrl_q, exp_flat());

        // random transfers
        for (int t = 0; t < 20; t++) begin
            logic [7:0] a;
            int n;
            a = ($urandom % 4 == 0) ? 8'($urandom) : 8'hD2;
            n = $urandom % 13;
            for (int i = 0; i < 16; i++) pay[i] = 8'($urandom);
            bus_start(); xfer(a, n, 1'b1);
            check("R9 random transfer state", ctrl_q, exp_flat());
        end

        // R1 power-on reset restores defaults
        rst_n = 1'b0; wait_clk(3);
        rst_n = 1'b1; wait_clk(3);
        for (int i = 0; i < NREG; i++) exp_regs[i] = 8'hFF;
        check("R1 reset restores defaults", ctrl_q, exp_flat());

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule